// File: doc/BRIEF.md
# One-Wire Bit-Slot Master

This block produces single-bit time slots on an open-drain one-wire line. A user asks for one slot at a time through a valid/ready handshake. The request names the slot kind: write a 0, write a 1, or read a bit. The block then pulls the line low and releases it on a microsecond schedule. That schedule comes from a prescaler divided down from the system clock. After the slot, the block keeps the line released for a recovery gap. Then it raises `done` for one cycle and returns a result bit.

The line is never driven high. The block has only a pull-low enable (`bus_pull`), and the line state (`bus_in`) comes back through a two-flop synchronizer. A read slot uses a short initiating low. The block then releases the line and samples it near the end of the window in which the slave's data is valid. The slot length is enforced even when the sample is taken early, and a new slot cannot start before the recovery gap ends.

The controller is a six-state machine:

- `ST_IDLE`: ready for a request. It goes to `ST_HOLD_LOW` for a write-0 and to `ST_INIT_LOW` for a write-1 or a read.
- `ST_INIT_LOW`: the short initiating low. It goes to `ST_RELEASED` after `LOW_US`.
- `ST_HOLD_LOW`: the write-0 low. It goes to `ST_RECOVER` after `SLOT_US`.
- `ST_RELEASED`: the line is free, and the read sample is taken at `SAMPLE_US`. It goes to `ST_RECOVER` at `SLOT_US`.
- `ST_RECOVER`: the recovery gap. It goes to `ST_FINISH` after `REC_US`.
- `ST_FINISH`: raises `done` and always goes back to `ST_IDLE`.

Top module: `owb_bit_master`

## Requirements
- R1: While reset is active and in the first cycle after it, `req_ready`=1, `bus_pull`=0, `done`=0 and `rd_bit`=0.
- R2: A request is accepted on a clock edge where `req_valid`=1, `req_ready`=1 and `req_kind` is 0, 1 or 2. From the next cycle, `req_ready` stays 0 up to and including the `done` cycle. A request presented while `req_ready`=0 is dropped and starts no slot.
- R3: For `req_kind`=1 (write-1) and `req_kind`=2 (read), `bus_pull` is 1 for exactly `LOW_US` microseconds (D·`LOW_US` cycles, D = clock cycles per µs). This starts in the cycle after acceptance, and the line is then released.
- R4: For `req_kind`=0 (write-0), `bus_pull` is 1 for exactly `SLOT_US` microseconds, starting in the cycle after acceptance.
- R5: `done` is 1 for exactly one cycle, D·(`SLOT_US`+`REC_US`) cycles after the accepting edge. During those cycles the line stays released for the last `REC_US` microseconds.
- R6: A read slot samples the synchronized line `SAMPLE_US` microseconds after the slot start. It reports `rd_bit`=1 if the line was high and 0 if it was low.
- R7: On write slots, `rd_bit` at `done` equals the bit written (0 for kind 0, 1 for kind 1).
- R8: `req_kind`=3 is reserved. Such a request starts no slot: `req_ready` stays 1, and `bus_pull` and `done` stay 0.
- R9: `bus_pull` is 0 whenever `req_ready` is 1.
- R10: `rd_bit` keeps its value after `done` until the next slot is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Slot request strobe |
| req_kind | input | 2 | Slot kind: 0 write-0, 1 write-1, 2 read, 3 reserved |
| req_ready | output | 1 | Block idle and able to accept a request |
| done | output | 1 | One-cycle pulse at the end of the recovery gap |
| rd_bit | output | 1 | Sampled bit (read) or written bit (write), valid at `done` |
| bus_pull | output | 1 | Pull-low enable for the open-drain line |
| bus_in | input | 1 | Line level, asynchronous |

## Verification
With D cycles per microsecond, `bus_pull` rises in the first cycle after the accepting edge. It falls D·`LOW_US` (or D·`SLOT_US` for write-0) cycles later. `done` appears exactly D·(`SLOT_US`+`REC_US`) cycles after that edge, and `req_ready` returns in the cycle after `done`.

The read sample is captured D·`SAMPLE_US` cycles after acceptance. It sees the line as it was two cycles earlier, because of the synchronizer. A slave hold of whole microseconds therefore reads 0 exactly when the hold is at least `SAMPLE_US`.

The bench counts cycles from the accepting edge and samples every output on the falling clock edge of each counted cycle. It compares each output against these cycle numbers over a sweep of slave hold lengths.

// File: rtl/owb_pkg.sv
package owb_pkg;

    // Slot kind encoding on the request port.
    typedef enum logic [1:0] {
        SLOT_W0   = 2'd0,
        SLOT_W1   = 2'd1,
        SLOT_RD   = 2'd2,
        SLOT_NONE = 2'd3
    } slot_kind_e;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_INIT_LOW = 3'd1,
        ST_HOLD_LOW = 3'd2,
        ST_RELEASED = 3'd3,
        ST_RECOVER  = 3'd4,
        ST_FINISH   = 3'd5
    } slot_state_e;

endpackage

// File: rtl/owb_tick_gen.sv
// Microsecond strobe: one-cycle pulse every DIV clocks, restarted by clear.
module owb_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clear || pre_q == LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = !clear && (pre_q == LAST);
        end else begin : g_pass
            assign tick = !clear;
        end
    endgenerate

endmodule

// File: rtl/owb_sync.sv
// Multi-stage synchronizer for the asynchronous line input.
module owb_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_VAL}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= RESET_VAL;
                end else begin
                    chain_q <= d;
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/owb_slot_ctrl.sv
// Slot sequencer: phases, microsecond counter, read sampling.
module owb_slot_ctrl
    import owb_pkg::*;
#(
    parameter int DIV       = 50,
    parameter int LOW_US    = 2,
    parameter int SAMPLE_US = 13,
    parameter int SLOT_US   = 65,
    parameter int REC_US    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       req_valid,
    input  slot_kind_e req_kind,
    input  logic       line_s,
    output logic       req_ready,
    output logic       done,
    output logic       rd_bit,
    output logic       bus_pull,
    output logic       timer_clear
);
    localparam int US_MAX    = (SLOT_US > REC_US) ? SLOT_US : REC_US;
    localparam int UW        = $clog2(US_MAX + 1);
    localparam logic [UW-1:0] LOW_LAST  = UW'(LOW_US - 1);
    localparam logic [UW-1:0] SMP_LAST  = UW'(SAMPLE_US - 1);
    localparam logic [UW-1:0] SLOT_LAST = UW'(SLOT_US - 1);
    localparam logic [UW-1:0] REC_LAST  = UW'(REC_US - 1);
    localparam int TOTAL_CYC = DIV * (SLOT_US + REC_US);
    localparam int LOW_CYC   = DIV * LOW_US;
    localparam int W0_CYC    = DIV * SLOT_US;
    localparam int BW        = $clog2(TOTAL_CYC + 2);
    localparam int LW        = $clog2(W0_CYC + 2);

    slot_state_e   state_q, state_d;
    slot_kind_e    kind_q;
    logic [UW-1:0] us_q;
    logic          rd_q;
    logic          accept;
    logic          enter_rec;
    logic          sample_now;

    assign accept     = req_valid && (state_q == ST_IDLE) && (req_kind != SLOT_NONE);
    assign enter_rec  = (state_d == ST_RECOVER) && (state_q != ST_RECOVER);
    assign sample_now = (state_q == ST_RELEASED) && (kind_q == SLOT_RD)
                        && tick && (us_q == SMP_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (req_kind == SLOT_W0) ? ST_HOLD_LOW : ST_INIT_LOW;
                end
            end
            ST_INIT_LOW: begin
                if (tick && us_q == LOW_LAST) state_d = ST_RELEASED;
            end
            ST_HOLD_LOW: begin
                if (tick && us_q == SLOT_LAST) state_d = ST_RECOVER;
            end
            ST_RELEASED: begin
                if (tick && us_q == SLOT_LAST) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (tick && us_q == REC_LAST) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Microsecond counter: slot time from slot start, restarted for recovery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_q <= '0;
        end else if (state_q == ST_IDLE) begin
            us_q <= '0;
        end else if (tick) begin
            us_q <= enter_rec ? '0 : us_q + 1'b1;
        end
    end

    // Accepted kind and result bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= SLOT_W0;
            rd_q   <= 1'b0;
        end else if (accept) begin
            kind_q <= req_kind;
            rd_q   <= (req_kind == SLOT_W1);
        end else if (sample_now) begin
            rd_q   <= line_s;
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        bus_pull    = (state_q == ST_INIT_LOW) || (state_q == ST_HOLD_LOW);
        done        = (state_q == ST_FINISH);
        timer_clear = (state_q == ST_IDLE) || (state_q == ST_FINISH);
        rd_bit      = rd_q;
    end

    // Checker counters
    logic [BW-1:0] busy_cnt;
    logic [LW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            low_run  <= '0;
        end else begin
            if (accept) begin
                busy_cnt <= '0;
            end else if (state_q != ST_IDLE) begin
                busy_cnt <= busy_cnt + 1'b1;
            end
            low_run <= bus_pull ? low_run + 1'b1 : '0;
        end
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_slot_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == BW'(TOTAL_CYC)));

    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_pull);

    a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !done) |=> !req_ready);

    a_r3_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_pull) |-> (low_run >= LW'(LOW_CYC)));

    a_r4_w0_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_pull) && kind_q == SLOT_W0) |-> (low_run == LW'(W0_CYC)));

endmodule

// File: rtl/owb_bit_master.sv
// One-wire bit-slot master top level.
module owb_bit_master
    import owb_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int LOW_US      = 2,
    parameter int SAMPLE_US   = 13,
    parameter int SLOT_US     = 65,
    parameter int REC_US      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    output logic       req_ready,
    output logic       done,
    output logic       rd_bit,
    output logic       bus_pull,
    input  logic       bus_in
);
    localparam int DIV = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

    logic tick;
    logic timer_clear;
    logic line_s;

    owb_tick_gen #(
        .DIV (DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .tick  (tick)
    );

    owb_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_in),
        .q     (line_s)
    );

    owb_slot_ctrl #(
        .DIV       (DIV),
        .LOW_US    (LOW_US),
        .SAMPLE_US (SAMPLE_US),
        .SLOT_US   (SLOT_US),
        .REC_US    (REC_US)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .req_valid   (req_valid),
        .req_kind    (slot_kind_e'(req_kind)),
        .line_s      (line_s),
        .req_ready   (req_ready),
        .done        (done),
        .rd_bit      (rd_bit),
        .bus_pull    (bus_pull),
        .timer_clear (timer_clear)
    );

endmodule

// File: tb/owb_bit_master_tb_top.sv
`timescale 1ns/1ps
module owb_bit_master_tb_top;

    localparam int CLK_HZ = 4_000_000;
    localparam int D      = CLK_HZ / 1_000_000;
    localparam int LOW    = 2;
    localparam int SMP    = 13;
    localparam int SLOT   = 65;
    localparam int REC    = 5;
    localparam int TOTAL  = D * (SLOT + REC);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic       req_ready, done, rd_bit, bus_pull;
    logic       slave_low = 1'b0;
    logic       bus_in;

    int checks = 0;
    int errors = 0;

    assign bus_in = !(bus_pull || slave_low);

    always #10 clk = ~clk;

    owb_bit_master #(
        .CLK_HZ    (CLK_HZ),
        .LOW_US    (LOW),
        .SAMPLE_US (SMP),
        .SLOT_US   (SLOT),
        .REC_US    (REC)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_ready (req_ready),
        .done      (done),
        .rd_bit    (rd_bit),
        .bus_pull  (bus_pull),
        .bus_in    (bus_in)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One slot; hold = slave low time in us for reads; poke = request while busy
    task automatic run_slot(input int kind, input int hold, input bit poke);
        int pull_len = (kind == 0) ? D * SLOT : D * LOW;
        int exp_rd   = (kind == 0) ? 0 : (kind == 1) ? 1 : ((hold >= SMP) ? 0 : 1);
        int pull_bad = -1, done_bad = -1, ready_bad = -1;
        int rd_at_done = -1;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind[1:0];
        @(posedge clk);
        for (int k = 0; k <= TOTAL + 2; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (poke && k == 100) begin req_valid = 1'b1; req_kind = 2'd0; end
            if (poke && k == 103) req_valid = 1'b0;
            slave_low = (kind == 2) && (k < hold * D);
            if (bus_pull !== (k < pull_len) && pull_bad < 0) pull_bad = k;
            if (done !== (k == TOTAL) && done_bad < 0) done_bad = k;
            if (req_ready !== (k > TOTAL) && ready_bad < 0) ready_bad = k;
            if (k == TOTAL) rd_at_done = int'(rd_bit);
            if (k == TOTAL + 2)
                check(rd_bit === rd_at_done[0], "R10", "rd_bit hold", int'(rd_bit), rd_at_done);
        end
        slave_low = 1'b0;
        if (kind == 0)
            check(pull_bad < 0, "R4", "write-0 pull mismatch cycle", pull_bad, -1);
        else
            check(pull_bad < 0, "R3", "init pull mismatch cycle", pull_bad, -1);
        check(done_bad < 0, "R5", "done mismatch cycle", done_bad, -1);
        check(ready_bad < 0, "R2", "ready mismatch cycle", ready_bad, -1);
        if (kind == 2)
            check(rd_at_done == exp_rd, "R6", $sformatf("read hold %0d us", hold), rd_at_done, exp_rd);
        else
            check(rd_at_done == exp_rd, "R7", "write result", rd_at_done, exp_rd);
    endtask

    task automatic run_reserved();
        int bad = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'd3;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (req_ready !== 1'b1 || bus_pull !== 1'b0 || done !== 1'b0) bad++;
        end
        req_valid = 1'b0;
        check(bad == 0, "R8", "reserved kind bad cycles", bad, 0);
        check(bus_pull === 1'b0, "R9", "line released when idle", int'(bus_pull), 0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && bus_pull === 1'b0 && done === 1'b0 && rd_bit === 1'b0,
              "R1", "outputs in reset", {req_ready, bus_pull, done, rd_bit}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && bus_pull === 1'b0 && done === 1'b0 && rd_bit === 1'b0,
              "R1", "outputs after reset", {req_ready, bus_pull, done, rd_bit}, 4'b1000);

        run_slot(0, 0, 1'b0);
        run_slot(1, 0, 1'b1);
        run_slot(0, 0, 1'b1);
        for (int h = 0; h <= 20; h++) run_slot(2, h, 1'b0);
        run_reserved();
        run_slot(2, 20, 1'b1);
        run_slot(1, 0, 1'b0);
        run_slot(2, 0, 1'b0);
        run_slot(0, 0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule